// File: doc/BRIEF.md
# MI Cache Line Coherence Controller

This block is the coherence controller for the lines of a small private first-level cache. The cache uses a protocol with two stable states: a line is either Modified (held exclusively and writable) or Invalid. The cache is direct-mapped and has `2**SET_W` sets. Each set keeps a line state and a tag. The processor presents load, fetch, store and replace requests, one per cycle, and each request is held until `stall` is low. The network side delivers one message per cycle: a data fill, a forwarded exclusive request, an invalidation, a writeback acknowledge or a writeback negative acknowledge.

Outgoing traffic is an exclusive request (GETX) or a put message to the home directory, or a data response to a requester. Each outgoing message appears after a fixed issue latency. Processor completions appear after a fixed response latency. Misses in flight hold an entry in a small transaction table, and a miss that finds the table full is stalled. Data storage, the directory and the interconnect are outside the block.

In any cycle, a network message has priority over the processor. A pending put retry comes next, and a processor request comes last.

Top module: `mi_line_coherence`

## Requirements
- R1: After reset every line is Invalid, the transaction table is empty, and `outValid`, `doneValid` and `stall` are low while no request is presented.
- R2: A load (`reqOp`=0), fetch (1) or store (2) to a set in Invalid is accepted when a transaction entry is free. It then emits GETX (`outType`=0) for `reqAddr` ISSUE_LAT cycles later, counting the accepting cycle as the first. The line becomes a read-pending state for a load or fetch, and a write-pending state for a store.
- R3: A load, fetch or store whose tag matches a Modified line completes with `doneValid`, `doneAddr`=`reqAddr`, and `doneStore` high only for a store. The completion appears RESP_LAT cycles later, counting the accepting cycle as the first.
- R4: A data fill (`netType`=0) to a matching line that is read-pending or write-pending does four things: it completes the miss (`doneStore` high only if the line was write-pending), it frees the transaction entry, it makes the line Modified, and it emits no message.
- R5: A replace (`reqOp`=3) of a matching Modified line emits a put (`outType`=1) for that address and moves the line to writeback-pending. A replace of a line that is not resident and Modified is accepted with no output.
- R6: A request to a set in any transient state (read-pending, write-pending, writeback-pending, retry-pending, or put-outstanding-after-loss) is stalled and has no effect.
- R7: A load, fetch or store that meets a Modified line with a different tag is stalled. The block emits a put for the resident (victim) address and moves that line to writeback-pending.
- R8: A negative acknowledge (`netType`=4) in writeback-pending moves the line to retry-pending. In the next cycle with no network message, the put is reissued and the line returns to writeback-pending. An acknowledge (`netType`=3) in writeback-pending, retry-pending or put-outstanding returns the line to Invalid. A negative acknowledge in put-outstanding also returns the line to Invalid.
- R9: A load, fetch or store miss to an Invalid set is stalled, and emits nothing, while every transaction entry is in use.
- R10: A forwarded exclusive request (`netType`=1) or an invalidation (2) to a matching Modified line emits a data response (`outType`=2) for that address and moves the line to Invalid. In writeback-pending or retry-pending, it emits the data response and moves the line to put-outstanding.
- R11: A processor request is stalled in any cycle that carries a network message, and in any cycle that reissues a put.
- R12: A network message whose tag does not match, or whose kind does not apply to the line's state, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqOp | input | 2 | 0 load, 1 fetch, 2 store, 3 replace |
| reqAddr | input | ADDR_W | Line address of the request |
| stall | output | 1 | Request not accepted this cycle |
| netValid | input | 1 | Network message present |
| netType | input | 3 | 0 data, 1 forwarded GETX, 2 invalidate, 3 writeback ack, 4 writeback nack |
| netAddr | input | ADDR_W | Line address of the network message |
| outValid | output | 1 | Outgoing message valid |
| outType | output | 2 | 0 GETX, 1 put, 2 data response |
| outAddr | output | ADDR_W | Line address of the outgoing message |
| doneValid | output | 1 | Processor access completed |
| doneAddr | output | ADDR_W | Line address of the completed access |
| doneStore | output | 1 | Completed access was a store |

## Verification
An outgoing message is due in cycle `a + ISSUE_LAT - 1`, where `a` is the cycle of the clock edge that accepted the triggering input. A completion is due in cycle `a + RESP_LAT - 1`. A put retry is timed from the cycle after the negative acknowledge. The stimulus tasks record the accepting cycle and push the expected message or completion, with its due cycle, into one of two queues. A monitor samples the outputs at the falling edge. It pops the oldest item and compares its kind, address and due cycle. It reports any output that arrives when no item is queued, and any queued item whose due cycle has passed. `stall` is combinational, so it is checked in the same cycle the request is driven.

// File: rtl/mi_pkg.sv
package mi_pkg;

  typedef enum logic [2:0] {
    LS_I   = 3'd0,
    LS_II  = 3'd1,
    LS_M   = 3'd2,
    LS_MI  = 3'd3,
    LS_MII = 3'd4,
    LS_IS  = 3'd5,
    LS_IM  = 3'd6
  } lineState_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_FETCH = 2'd1,
    OP_STORE = 2'd2,
    OP_REPL  = 2'd3
  } procOp_e;

  typedef enum logic [2:0] {
    NM_DATA    = 3'd0,
    NM_FWDX    = 3'd1,
    NM_INV     = 3'd2,
    NM_WB_ACK  = 3'd3,
    NM_WB_NACK = 3'd4
  } netMsg_e;

  typedef enum logic [1:0] {
    OM_GETX = 2'd0,
    OM_PUT  = 2'd1,
    OM_DATA = 2'd2
  } outMsg_e;

  typedef enum logic [1:0] {
    AS_PROC   = 2'd0,
    AS_NET    = 2'd1,
    AS_VICTIM = 2'd2,
    AS_RETRY  = 2'd3
  } addrSel_e;

  typedef struct packed {
    logic       lineWr;
    addrSel_e   lineSel;
    lineState_e lineNext;
    logic       tagWr;
    logic       tbeAlloc;
    logic       tbeFree;
    logic       msgSend;
    outMsg_e    msgKind;
    addrSel_e   msgSel;
    logic       doneFire;
    logic       doneStore;
    addrSel_e   doneSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/mi_delay.sv
module mi_delay #(
  parameter int WIDTH = 8,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);

  logic [LAT-1:0]   vPipe;
  logic [WIDTH-1:0] dPipe [LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
      for (int i = 0; i < LAT; i++) dPipe[i] <= '0;
    end else begin
      vPipe[0] <= inValid;
      dPipe[0] <= inData;
      for (int i = 1; i < LAT; i++) begin
        vPipe[i] <= vPipe[i-1];
        dPipe[i] <= dPipe[i-1];
      end
    end
  end

  assign outValid = vPipe[LAT-1];
  assign outData  = dPipe[LAT-1];

endmodule

// File: rtl/mi_tbe_table.sv
module mi_tbe_table #(
  parameter int ADDR_W  = 8,
  parameter int NUM_TBE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              free,
  input  logic [ADDR_W-1:0] freeAddr,
  output logic              full
);

  logic [NUM_TBE-1:0] busyVec;
  logic [NUM_TBE-1:0] grantVec;
  logic [NUM_TBE-1:0] matchVec;

  always_comb begin
    logic taken;
    taken    = 1'b0;
    grantVec = '0;
    for (int i = 0; i < NUM_TBE; i++) begin
      if (!busyVec[i] && !taken) begin
        grantVec[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_TBE; g++) begin : gEntry
    logic              entBusy;
    logic [ADDR_W-1:0] entAddr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entBusy <= 1'b0;
        entAddr <= '0;
      end else if (alloc && grantVec[g]) begin
        entBusy <= 1'b1;
        entAddr <= allocAddr;
      end else if (free && matchVec[g]) begin
        entBusy <= 1'b0;
      end
    end

    assign busyVec[g]  = entBusy;
    assign matchVec[g] = entBusy && (entAddr == freeAddr);
  end

  assign full = &busyVec;

endmodule

// File: rtl/mi_line_dp.sv
module mi_line_dp
  import mi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SET_W     = 2,
  parameter int NUM_TBE   = 2,
  parameter int ISSUE_LAT = 2,
  parameter int RESP_LAT  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] netAddr,
  input  ctrlStrobe_t       strobe,
  output lineState_e        procState,
  output logic              procTagHit,
  output lineState_e        netState,
  output logic              netTagHit,
  output logic              retryFound,
  output logic              tbeFull,
  output logic              outValid,
  output logic [1:0]        outType,
  output logic [ADDR_W-1:0] outAddr,
  output logic              doneValid,
  output logic [ADDR_W-1:0] doneAddr,
  output logic              doneStore
);

  localparam int NUM_SETS = 1 << SET_W;
  localparam int TAG_W    = ADDR_W - SET_W;
  localparam int MSG_W    = 2 + ADDR_W;
  localparam int DONE_W   = 1 + ADDR_W;

  lineState_e       stateArr [NUM_SETS];
  logic [TAG_W-1:0] tagArr   [NUM_SETS];

  logic [SET_W-1:0] procSet, netSet, retrySet, lineIdx;
  logic [TAG_W-1:0] procTag, netTag;
  logic [ADDR_W-1:0] victimAddr, retryAddr, msgAddr, doneSrcAddr;

  assign procSet = reqAddr[SET_W-1:0];
  assign procTag = reqAddr[ADDR_W-1:SET_W];
  assign netSet  = netAddr[SET_W-1:0];
  assign netTag  = netAddr[ADDR_W-1:SET_W];

  assign procState  = stateArr[procSet];
  assign procTagHit = (tagArr[procSet] == procTag);
  assign netState   = stateArr[netSet];
  assign netTagHit  = (tagArr[netSet] == netTag);

  always_comb begin
    retryFound = 1'b0;
    retrySet   = '0;
    for (int s = NUM_SETS - 1; s >= 0; s--) begin
      if (stateArr[s] == LS_MII) begin
        retryFound = 1'b1;
        retrySet   = SET_W'(s);
      end
    end
  end

  assign victimAddr = {tagArr[procSet], procSet};
  assign retryAddr  = {tagArr[retrySet], retrySet};

  always_comb begin
    case (strobe.lineSel)
      AS_NET:   lineIdx = netSet;
      AS_RETRY: lineIdx = retrySet;
      default:  lineIdx = procSet;
    endcase
    case (strobe.msgSel)
      AS_NET:    msgAddr = netAddr;
      AS_VICTIM: msgAddr = victimAddr;
      AS_RETRY:  msgAddr = retryAddr;
      default:   msgAddr = reqAddr;
    endcase
    doneSrcAddr = (strobe.doneSel == AS_NET) ? netAddr : reqAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        stateArr[s] <= LS_I;
        tagArr[s]   <= '0;
      end
    end else begin
      if (strobe.lineWr) stateArr[lineIdx] <= strobe.lineNext;
      if (strobe.tagWr)  tagArr[procSet]   <= procTag;
    end
  end

  mi_tbe_table #(
    .ADDR_W  (ADDR_W),
    .NUM_TBE (NUM_TBE)
  ) i_tbe (
    .clk       (clk),
    .rstN      (rstN),
    .alloc     (strobe.tbeAlloc),
    .allocAddr (reqAddr),
    .free      (strobe.tbeFree),
    .freeAddr  (netAddr),
    .full      (tbeFull)
  );

  logic [MSG_W-1:0]  msgOut;
  logic [DONE_W-1:0] doneOut;

  mi_delay #(
    .WIDTH (MSG_W),
    .LAT   (ISSUE_LAT)
  ) i_msgPipe (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (strobe.msgSend),
    .inData   ({strobe.msgKind, msgAddr}),
    .outValid (outValid),
    .outData  (msgOut)
  );

  mi_delay #(
    .WIDTH (DONE_W),
    .LAT   (RESP_LAT)
  ) i_donePipe (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (strobe.doneFire),
    .inData   ({strobe.doneStore, doneSrcAddr}),
    .outValid (doneValid),
    .outData  (doneOut)
  );

  assign outType   = msgOut[MSG_W-1 -: 2];
  assign outAddr   = msgOut[ADDR_W-1:0];
  assign doneStore = doneOut[DONE_W-1];
  assign doneAddr  = doneOut[ADDR_W-1:0];

endmodule

// File: rtl/mi_line_fsm.sv
module mi_line_fsm
  import mi_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        netValid,
  input  logic [2:0]  netType,
  input  lineState_e  procState,
  input  logic        procTagHit,
  input  lineState_e  netState,
  input  logic        netTagHit,
  input  logic        retryFound,
  input  logic        tbeFull,
  output ctrlStrobe_t strobe,
  output logic        stall
);

  procOp_e op;
  netMsg_e netKind;
  logic    procBusy;

  assign op       = procOp_e'(reqOp);
  assign netKind  = netMsg_e'(netType);
  assign procBusy = (procState != LS_I) && (procState != LS_M);

  always_comb begin
    strobe = '0;
    stall  = 1'b0;
    if (netValid) begin
      stall          = reqValid;
      strobe.lineSel = AS_NET;
      strobe.msgSel  = AS_NET;
      strobe.doneSel = AS_NET;
      if (netTagHit) begin
        case (netKind)
          NM_DATA: begin
            if (netState == LS_IS || netState == LS_IM) begin
              strobe.lineWr    = 1'b1;
              strobe.lineNext  = LS_M;
              strobe.tbeFree   = 1'b1;
              strobe.doneFire  = 1'b1;
              strobe.doneStore = (netState == LS_IM);
            end
          end
          NM_FWDX, NM_INV: begin
            if (netState == LS_M) begin
              strobe.lineWr   = 1'b1;
              strobe.lineNext = LS_I;
              strobe.msgSend  = 1'b1;
              strobe.msgKind  = OM_DATA;
            end else if (netState == LS_MI || netState == LS_MII) begin
              strobe.lineWr   = 1'b1;
              strobe.lineNext = LS_II;
              strobe.msgSend  = 1'b1;
              strobe.msgKind  = OM_DATA;
            end
          end
          NM_WB_ACK: begin
            if (netState == LS_MI || netState == LS_MII || netState == LS_II) begin
              strobe.lineWr   = 1'b1;
              strobe.lineNext = LS_I;
            end
          end
          NM_WB_NACK: begin
            if (netState == LS_MI) begin
              strobe.lineWr   = 1'b1;
              strobe.lineNext = LS_MII;
            end else if (netState == LS_II) begin
              strobe.lineWr   = 1'b1;
              strobe.lineNext = LS_I;
            end
          end
          default: ;
        endcase
      end
    end else if (retryFound) begin
      stall           = reqValid;
      strobe.lineWr   = 1'b1;
      strobe.lineSel  = AS_RETRY;
      strobe.lineNext = LS_MI;
      strobe.msgSend  = 1'b1;
      strobe.msgKind  = OM_PUT;
      strobe.msgSel   = AS_RETRY;
    end else if (reqValid) begin
      strobe.lineSel = AS_PROC;
      strobe.msgSel  = AS_PROC;
      strobe.doneSel = AS_PROC;
      if (procBusy) begin
        stall = 1'b1;
      end else if (procState == LS_M) begin
        if (procTagHit) begin
          if (op == OP_REPL) begin
            strobe.lineWr   = 1'b1;
            strobe.lineNext = LS_MI;
            strobe.msgSend  = 1'b1;
            strobe.msgKind  = OM_PUT;
          end else begin
            strobe.doneFire  = 1'b1;
            strobe.doneStore = (op == OP_STORE);
          end
        end else if (op != OP_REPL) begin
          stall           = 1'b1;
          strobe.lineWr   = 1'b1;
          strobe.lineNext = LS_MI;
          strobe.msgSend  = 1'b1;
          strobe.msgKind  = OM_PUT;
          strobe.msgSel   = AS_VICTIM;
        end
      end else if (op != OP_REPL) begin
        if (tbeFull) begin
          stall = 1'b1;
        end else begin
          strobe.tbeAlloc = 1'b1;
          strobe.tagWr    = 1'b1;
          strobe.lineWr   = 1'b1;
          strobe.lineNext = (op == OP_STORE) ? LS_IM : LS_IS;
          strobe.msgSend  = 1'b1;
          strobe.msgKind  = OM_GETX;
        end
      end
    end
  end

endmodule

// File: rtl/mi_line_coherence.sv
module mi_line_coherence
  import mi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SET_W     = 2,
  parameter int NUM_TBE   = 2,
  parameter int ISSUE_LAT = 2,
  parameter int RESP_LAT  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              stall,
  input  logic              netValid,
  input  logic [2:0]        netType,
  input  logic [ADDR_W-1:0] netAddr,
  output logic              outValid,
  output logic [1:0]        outType,
  output logic [ADDR_W-1:0] outAddr,
  output logic              doneValid,
  output logic [ADDR_W-1:0] doneAddr,
  output logic              doneStore
);

  ctrlStrobe_t strobe;
  lineState_e  procState, netState;
  logic        procTagHit, netTagHit, retryFound, tbeFull;

  mi_line_fsm i_fsm (
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .netValid   (netValid),
    .netType    (netType),
    .procState  (procState),
    .procTagHit (procTagHit),
    .netState   (netState),
    .netTagHit  (netTagHit),
    .retryFound (retryFound),
    .tbeFull    (tbeFull),
    .strobe     (strobe),
    .stall      (stall)
  );

  mi_line_dp #(
    .ADDR_W    (ADDR_W),
    .SET_W     (SET_W),
    .NUM_TBE   (NUM_TBE),
    .ISSUE_LAT (ISSUE_LAT),
    .RESP_LAT  (RESP_LAT)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .netAddr    (netAddr),
    .strobe     (strobe),
    .procState  (procState),
    .procTagHit (procTagHit),
    .netState   (netState),
    .netTagHit  (netTagHit),
    .retryFound (retryFound),
    .tbeFull    (tbeFull),
    .outValid   (outValid),
    .outType    (outType),
    .outAddr    (outAddr),
    .doneValid  (doneValid),
    .doneAddr   (doneAddr),
    .doneStore  (doneStore)
  );

endmodule

// File: rtl/mi_line_checker.sv
module mi_line_checker
  import mi_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqOp,
  input logic       netValid,
  input logic       stall,
  input logic       outValid,
  input logic [1:0] outType,
  input logic       doneValid,
  input lineState_e procState,
  input logic       retryFound,
  input logic       tbeFull
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !doneValid));

  p_legal_out_kind_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outType != 2'd3));

  p_stall_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> reqValid);

  p_full_table_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !netValid && !retryFound && procState == LS_I &&
     reqOp != 2'd3 && tbeFull) |-> stall);

  p_net_priority_r11: assert property (@(posedge clk) disable iff (!rstN)
    (netValid && reqValid) |-> stall);

  p_retry_priority_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!netValid && retryFound && reqValid) |-> stall);

endmodule

bind mi_line_coherence mi_line_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .netValid   (netValid),
  .stall      (stall),
  .outValid   (outValid),
  .outType    (outType),
  .doneValid  (doneValid),
  .procState  (procState),
  .retryFound (retryFound),
  .tbeFull    (tbeFull)
);

// File: tb/test_mi_line_coherence.sv
module test_mi_line_coherence;

  localparam int ISSUE_LAT = 2;
  localparam int RESP_LAT  = 12;

  localparam logic [1:0] LOAD = 2'd0, FETCH = 2'd1, STORE = 2'd2, REPL = 2'd3;
  localparam logic [2:0] N_DATA = 3'd0, N_FWDX = 3'd1, N_INV = 3'd2, N_ACK = 3'd3, N_NACK = 3'd4;
  localparam logic [1:0] O_GETX = 2'd0, O_PUT = 2'd1, O_DATA = 2'd2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [7:0] reqAddr = '0;
  logic       stall;
  logic       netValid = 1'b0;
  logic [2:0] netType = '0;
  logic [7:0] netAddr = '0;
  logic       outValid;
  logic [1:0] outType;
  logic [7:0] outAddr;
  logic       doneValid;
  logic [7:0] doneAddr;
  logic       doneStore;

  always #4 clk = ~clk;

  mi_line_coherence i_mi_line_coherence (
    .clk (clk), .rstN (rstN),
    .reqValid (reqValid), .reqOp (reqOp), .reqAddr (reqAddr), .stall (stall),
    .netValid (netValid), .netType (netType), .netAddr (netAddr),
    .outValid (outValid), .outType (outType), .outAddr (outAddr),
    .doneValid (doneValid), .doneAddr (doneAddr), .doneStore (doneStore)
  );

  typedef struct {
    int         due;
    logic [1:0] kind;
    logic [7:0] addr;
    string      req;
  } msgExp_t;

  typedef struct {
    int         due;
    logic       store;
    logic [7:0] addr;
    string      req;
  } doneExp_t;

  msgExp_t  msgQ[$];
  doneExp_t doneQ[$];

  int cycle = 0;
  int acceptCyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic expectMsg(input logic [1:0] kind, input logic [7:0] a, input string req);
    msgQ.push_back('{acceptCyc + ISSUE_LAT - 1, kind, a, req});
  endtask

  task automatic expectDone(input logic st, input logic [7:0] a, input string req);
    doneQ.push_back('{acceptCyc + RESP_LAT - 1, st, a, req});
  endtask

  task automatic proc(input logic [1:0] op, input logic [7:0] a, input bit expStall, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a;
    #1;
    chk(stall == expStall, req, int'(stall), int'(expStall));
    acceptCyc = cycle + 1;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic net(input logic [2:0] t, input logic [7:0] a);
    @(negedge clk);
    netValid = 1'b1; netType = t; netAddr = a;
    acceptCyc = cycle + 1;
    @(posedge clk);
    #1 netValid = 1'b0;
  endtask

  task automatic both(input logic [1:0] op, input logic [7:0] a, input logic [2:0] t,
                      input logic [7:0] na, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a;
    netValid = 1'b1; netType = t; netAddr = na;
    #1;
    chk(stall == 1'b1, req, int'(stall), 1);
    acceptCyc = cycle + 1;
    @(posedge clk);
    #1 begin reqValid = 1'b0; netValid = 1'b0; end
  endtask

  // Monitor: compares outputs against the scoreboard queues.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (msgQ.size() == 0) begin
          chk(1'b0, "unexpected message", int'(outAddr), -1);
        end else begin
          msgExp_t e;
          e = msgQ.pop_front();
          chk(outType == e.kind, e.req, int'(outType), int'(e.kind));
          chk(outAddr == e.addr, e.req, int'(outAddr), int'(e.addr));
          chk(cycle == e.due, e.req, cycle, e.due);
        end
      end else if (msgQ.size() != 0 && msgQ[0].due < cycle) begin
        chk(1'b0, msgQ[0].req, cycle, msgQ[0].due);
        void'(msgQ.pop_front());
      end
      if (doneValid) begin
        if (doneQ.size() == 0) begin
          chk(1'b0, "unexpected completion", int'(doneAddr), -1);
        end else begin
          doneExp_t d;
          d = doneQ.pop_front();
          chk(doneAddr == d.addr, d.req, int'(doneAddr), int'(d.addr));
          chk(doneStore == d.store, d.req, int'(doneStore), int'(d.store));
          chk(cycle == d.due, d.req, cycle, d.due);
        end
      end else if (doneQ.size() != 0 && doneQ[0].due < cycle) begin
        chk(1'b0, doneQ[0].req, cycle, doneQ[0].due);
        void'(doneQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cycle, 0);
    wrapUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(stall == 1'b0, "R1 stall idle", int'(stall), 0);
    chk(doneValid == 1'b0, "R1 doneValid idle", int'(doneValid), 0);

    // R2 load miss, R6 stall on pending line, R2 store miss, R9 table full
    proc(LOAD, 8'h10, 1'b0, "R2 load miss");    expectMsg(O_GETX, 8'h10, "R2 getx 0x10");
    proc(LOAD, 8'h10, 1'b1, "R6 stall read-pending");
    proc(STORE, 8'h21, 1'b0, "R2 store miss");  expectMsg(O_GETX, 8'h21, "R2 getx 0x21");
    proc(LOAD, 8'h32, 1'b1, "R9 stall table full");
    // R4 fill frees entry
    net(N_DATA, 8'h10);                         expectDone(1'b0, 8'h10, "R4 fill load");
    proc(FETCH, 8'h32, 1'b0, "R2 fetch miss");  expectMsg(O_GETX, 8'h32, "R2 getx 0x32");
    net(N_DATA, 8'h21);                         expectDone(1'b1, 8'h21, "R4 fill store");
    net(N_DATA, 8'h32);                         expectDone(1'b0, 8'h32, "R4 fill fetch");
    // R3 hits
    proc(LOAD, 8'h10, 1'b0, "R3 load hit");     expectDone(1'b0, 8'h10, "R3 load hit done");
    proc(STORE, 8'h21, 1'b0, "R3 store hit");   expectDone(1'b1, 8'h21, "R3 store hit done");
    // R12 ignored messages
    net(N_DATA, 8'h10);
    net(N_ACK, 8'h55);
    net(N_INV, 8'h55);
    proc(LOAD, 8'h10, 1'b0, "R12 line kept");   expectDone(1'b0, 8'h10, "R12 still modified");
    // R7 victim put
    proc(STORE, 8'h50, 1'b1, "R7 conflict stall"); expectMsg(O_PUT, 8'h10, "R7 victim put");
    proc(STORE, 8'h50, 1'b1, "R6 stall writeback-pending");
    // R8 nack then retry; R11 retry cycle stalls
    net(N_NACK, 8'h10);
    proc(LOAD, 8'h32, 1'b1, "R11 stall on retry cycle"); expectMsg(O_PUT, 8'h10, "R8 put retry");
    net(N_ACK, 8'h10);
    proc(STORE, 8'h50, 1'b0, "R8 line invalid after ack"); expectMsg(O_GETX, 8'h50, "R8 getx 0x50");
    net(N_DATA, 8'h50);                         expectDone(1'b1, 8'h50, "R4 fill store 0x50");
    // R10 invalidate in M
    net(N_INV, 8'h50);                          expectMsg(O_DATA, 8'h50, "R10 data on inv");
    proc(LOAD, 8'h50, 1'b0, "R10 invalid after inv"); expectMsg(O_GETX, 8'h50, "R10 getx after inv");
    net(N_DATA, 8'h50);                         expectDone(1'b0, 8'h50, "R4 fill load 0x50");
    // R5 replace, R10 forward in writeback-pending, R8 nack in put-outstanding
    proc(REPL, 8'h50, 1'b0, "R5 replace modified"); expectMsg(O_PUT, 8'h50, "R5 put");
    net(N_FWDX, 8'h50);                         expectMsg(O_DATA, 8'h50, "R10 data on fwd");
    proc(LOAD, 8'h50, 1'b1, "R6 stall put-outstanding");
    net(N_NACK, 8'h50);
    proc(LOAD, 8'h50, 1'b0, "R8 nack in put-outstanding"); expectMsg(O_GETX, 8'h50, "R8 getx after nack");
    // R11 network priority
    both(LOAD, 8'h21, N_DATA, 8'h50, "R11 net priority"); expectDone(1'b0, 8'h50, "R11 net fill");
    proc(LOAD, 8'h21, 1'b0, "R11 retry accepted"); expectDone(1'b0, 8'h21, "R11 hit after");
    // R5 replace of absent line
    proc(REPL, 8'h13, 1'b0, "R5 replace absent");

    repeat (RESP_LAT + 6) @(negedge clk);
    chk(msgQ.size() == 0, "R2 message queue drained", msgQ.size(), 0);
    chk(doneQ.size() == 0, "R3 completion queue drained", doneQ.size(), 0);
    wrapUp();
  end

endmodule